// File: doc/BRIEF.md
# UART Byte Queue and Trigger Manager

This block sits between a UART's host-side register access and its serializer and deserializer. Outgoing bytes written by the host collect in a transmit queue that the serializer drains. Bytes delivered by the deserializer collect in a receive queue that the host drains one byte per read. Each queue holds 64 bytes. A mode input can turn both queues off, and each then behaves as a single-byte holding register whose trigger level is fixed at one. Reset leaves the queues off.

For each direction the block compares the queue level with a trigger level set by the host. It drives an interrupt request and a DMA request from that comparison. The receive side uses the number of stored bytes. The transmit side uses the number of free slots.

There are three flow rules. On the host write channel, a byte transfers only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the byte is discarded, and the host must hold it and present it again. On the serializer channel, a byte leaves only when `tx_out_valid` and `tx_out_ready` are both high. `tx_out_data` stays fixed until that happens. The deserializer channel has no back-pressure: a byte that arrives while the receive queue is full is dropped, and the block records the loss in a sticky overflow flag.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset, both queues are empty and off, `rd_data` is 0, `rx_ovf` is 0, `tx_irq`/`tx_dma` are 1 and `rx_irq`/`rx_dma` are 0.
- R2: With queues on, each queue holds up to 64 bytes. `tx_full` is 1 exactly when the transmit queue holds its capacity, and `wr_ready` is its inverse outside a flush cycle.
- R3: A host write in a cycle with `wr_ready` low changes nothing. Transmit contents and order are unaffected.
- R4: With queues off, each direction holds at most one byte, and both trigger levels are 1 whatever is programmed.
- R5: `rd_en` with a non-empty receive queue loads the oldest byte into `rd_data` on the next cycle and removes it. With an empty queue, `rd_data` keeps its value and nothing is removed.
- R6: A received byte that arrives while the receive queue is full is dropped. The stored bytes stay intact, and `rx_ovf` goes to 1 on the next cycle.
- R7: `status_rd` clears `rx_ovf` on the next cycle. If a drop happens in the same cycle as `status_rd`, the flag stays set.
- R8: `rx_irq` and `rx_dma` are 1 exactly when the receive fill is at or above the effective receive trigger level.
- R9: `tx_irq` and `tx_dma` are 1 exactly when the free transmit slots are at or above the effective transmit trigger level.
- R10: A programmed trigger level of 0 acts as 1, and a level above 64 acts as 64.
- R11: In a cycle where `fifo_en` differs from its registered value, both queues are emptied. In that cycle `wr_ready` and `tx_out_valid` are 0, `rd_en` is ignored, and an incoming received byte is discarded without setting `rx_ovf`.
- R12: `tx_out_valid` is 1 when the transmit queue is non-empty and no flush is in progress. `tx_out_data` is the oldest byte, and a handshake removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 64-byte queues, 0 = single-byte holding registers |
| tx_trig | input | 7 | Transmit trigger level (free slots) |
| rx_trig | input | 7 | Receive trigger level (stored bytes) |
| wr_valid | input | 1 | Host offers a transmit byte |
| wr_data | input | 8 | Transmit byte from host |
| wr_ready | output | 1 | Transmit queue accepts a byte |
| tx_out_valid | output | 1 | Byte available to the serializer |
| tx_out_data | output | 8 | Oldest transmit byte |
| tx_out_ready | input | 1 | Serializer takes the byte |
| rx_in_valid | input | 1 | Deserializer delivers a byte |
| rx_in_data | input | 8 | Received byte |
| rd_en | input | 1 | Host read of the receive register |
| rd_data | output | 8 | Last byte read from the receive queue |
| status_rd | input | 1 | Host status read; clears overflow |
| tx_full | output | 1 | Transmit queue full |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dma | output | 1 | Transmit DMA request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma | output | 1 | Receive DMA request |

## Verification
The function pair that most needs care is receive overflow meeting a status read. When a byte is dropped in the same cycle that `status_rd` clears the flag, the set must win. The bench fills the receive queue to capacity, then pulses `rx_in_valid` and `status_rd` together. It expects `rx_ovf` to read 1 afterwards and to return to 0 only after a separate status read. A randomised phase also raises these two inputs together at random. There a per-cycle reference model applies the same priority, and any disagreement is reported.

// File: rtl/uft_pkg.sv
package uft_pkg;

  // Effective trigger level: 1 when queues are off or level is 0,
  // saturated at the queue depth when programmed above it.
  function automatic int unsigned eff_level(input logic en,
                                            input int unsigned lvl,
                                            input int unsigned depth);
    if (!en || lvl == 0) return 1;
    if (lvl > depth) return depth;
    return lvl;
  endfunction

endpackage

// File: rtl/uft_queue.sv
module uft_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok;

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(count));

  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !flush) |=> $stable(rptr));

  // R2
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !single) |=> (count <= CW'(DEPTH)));

endmodule

// File: rtl/uft_level.sv
module uft_level #(
  parameter int DEPTH = 64,
  localparam int TW   = $clog2(DEPTH + 1)
) (
  input  logic          en,
  input  logic [TW-1:0] lvl,
  input  logic [TW-1:0] fill,
  output logic          hit
);

  logic [TW-1:0] eff;

  assign eff = TW'(uft_pkg::eff_level(en, int'(unsigned'(lvl)), DEPTH));
  assign hit = (fill >= eff);

endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int TW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [TW-1:0] tx_trig,
  input  logic [TW-1:0] rx_trig,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  output logic          wr_ready,
  output logic          tx_out_valid,
  output logic [W-1:0]  tx_out_data,
  input  logic          tx_out_ready,
  input  logic          rx_in_valid,
  input  logic [W-1:0]  rx_in_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          status_rd,
  output logic          tx_full,
  output logic          rx_ovf,
  output logic          tx_irq,
  output logic          tx_dma,
  output logic          rx_irq,
  output logic          rx_dma
);

  logic          en_q, flush, single;
  logic [TW-1:0] tx_cnt, rx_cnt, cap;
  logic          tx_full_i, tx_empty, rx_full, rx_empty;
  logic [W-1:0]  rx_head;
  logic          drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush  = fifo_en ^ en_q;
  assign single = !en_q;
  assign cap    = single ? TW'(1) : TW'(DEPTH);

  uft_queue #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .single(single), .flush(flush),
    .push(wr_valid), .din(wr_data), .pop(tx_out_ready),
    .dout(tx_out_data), .count(tx_cnt), .full(tx_full_i), .empty(tx_empty)
  );

  uft_queue #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .single(single), .flush(flush),
    .push(rx_in_valid), .din(rx_in_data), .pop(rd_en),
    .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign wr_ready     = !tx_full_i && !flush;
  assign tx_out_valid = !tx_empty && !flush;
  assign tx_full      = tx_full_i;
  assign drop         = rx_in_valid && rx_full && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rd_data <= '0;
    else if (rd_en && !rx_empty && !flush) rd_data <= rx_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_ovf <= 1'b0;
    else if (drop)      rx_ovf <= 1'b1;
    else if (status_rd) rx_ovf <= 1'b0;
  end

  // Channel 0 = transmit (free slots), channel 1 = receive (stored bytes)
  logic [TW-1:0] lvl_a  [2];
  logic [TW-1:0] fill_a [2];
  logic          hit_a  [2];

  assign lvl_a[0]  = tx_trig;
  assign fill_a[0] = cap - tx_cnt;
  assign lvl_a[1]  = rx_trig;
  assign fill_a[1] = rx_cnt;

  for (genvar i = 0; i < 2; i++) begin : g_trig
    uft_level #(.DEPTH(DEPTH)) u_lvl (
      .en(en_q), .lvl(lvl_a[i]), .fill(fill_a[i]), .hit(hit_a[i])
    );
  end

  assign tx_irq = hit_a[0];
  assign tx_dma = hit_a[0];
  assign rx_irq = hit_a[1];
  assign rx_dma = hit_a[1];

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_full && !flush) |=> rx_ovf);

  // R7
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(rx_in_valid && rx_full && !flush)) |=> !rx_ovf);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_empty) |=> $stable(rd_data));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tx_empty && rx_empty));

endmodule

// File: tb/uart_fifo_trig_test.sv
`timescale 1ns/1ps
module uart_fifo_trig_test;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0;
  logic [6:0] tx_trig = 0, rx_trig = 0;
  logic wr_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rd_en = 0, status_rd = 0;
  logic [7:0] wr_data = 0, rx_in_data = 0;
  logic wr_ready, tx_out_valid, tx_full, rx_ovf, tx_irq, tx_dma, rx_irq, rx_dma;
  logic [7:0] tx_out_data, rd_data;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_fifo_trig uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rd_en(rd_en), .rd_data(rd_data),
    .status_rd(status_rd), .tx_full(tx_full), .rx_ovf(rx_ovf),
    .tx_irq(tx_irq), .tx_dma(tx_dma), .rx_irq(rx_irq), .rx_dma(rx_dma)
  );

  // Behavioural reference
  bit m_mode = 0, m_ovf = 0;
  int m_tx[$], m_rx[$];
  int m_rdd = 0;

  function automatic int level(bit mode, int lvl);
    if (!mode) return 1;
    if (lvl < 1) return 1;
    if (lvl > 64) return 64;
    return lvl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ovf = 0; m_tx.delete(); m_rx.delete(); m_rdd = 0;
    end else begin
      int cap;
      bit fl, drop;
      cap  = m_mode ? 64 : 1;
      fl   = (fifo_en != m_mode);
      drop = 0;
      if (fl) begin
        m_tx.delete(); m_rx.delete();
      end else begin
        int tsz, rsz;
        tsz = m_tx.size(); rsz = m_rx.size();
        if (tx_out_ready && tsz > 0) void'(m_tx.pop_front());
        if (wr_valid && tsz < cap) m_tx.push_back(int'(wr_data));
        if (rd_en && rsz > 0) m_rdd = m_rx.pop_front();
        if (rx_in_valid && rsz < cap) m_rx.push_back(int'(rx_in_data));
        drop = rx_in_valid && rsz >= cap;
      end
      if (drop) m_ovf = 1;
      else if (status_rd) m_ovf = 0;
      m_mode = fifo_en;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int cap, tfree;
    bit fl, tq, rq;
    string t_tag, r_tag, f_tag;
    cap   = m_mode ? 64 : 1;
    fl    = (fifo_en != m_mode);
    tfree = cap - m_tx.size();
    tq    = tfree >= level(m_mode, int'(tx_trig));
    rq    = m_rx.size() >= level(m_mode, int'(rx_trig));
    t_tag = (m_mode && (tx_trig == 0 || tx_trig > 64)) ? "R10" : "R9";
    r_tag = (m_mode && (rx_trig == 0 || rx_trig > 64)) ? "R10" : "R8";
    f_tag = fl ? "R11" : "R3";
    chk(tx_full == (m_tx.size() >= cap), m_mode ? "R2" : "R4", "tx_full", tx_full, m_tx.size() >= cap);
    chk(wr_ready == (!fl && m_tx.size() < cap), f_tag, "wr_ready", wr_ready, !fl && m_tx.size() < cap);
    chk(tx_out_valid == (!fl && m_tx.size() > 0), fl ? "R11" : "R12", "tx_out_valid",
        tx_out_valid, !fl && m_tx.size() > 0);
    if (m_tx.size() > 0)
      chk(int'(tx_out_data) == m_tx[0], "R12", "tx_out_data", tx_out_data, m_tx[0]);
    chk(int'(rd_data) == m_rdd, "R5", "rd_data", rd_data, m_rdd);
    chk(rx_ovf == m_ovf, "R6", "rx_ovf", rx_ovf, m_ovf);
    chk(tx_irq == tq && tx_dma == tq, t_tag, "tx_req", tx_irq, tq);
    chk(rx_irq == rq && rx_dma == rq, r_tag, "rx_req", rx_irq, rq);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr_valid = 0; tx_out_ready = 0; rx_in_valid = 0; rd_en = 0; status_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(tx_irq && tx_dma, "R1", "tx_req after reset", tx_irq, 1);
    chk(!rx_irq && !rx_dma, "R1", "rx_req after reset", rx_irq, 0);
    chk(rd_data == 0 && !rx_ovf && !tx_full, "R1", "rd_data/ovf/full", rd_data, 0);

    // R4 single-byte holding registers with a high programmed trigger
    tx_trig = 40; rx_trig = 40;
    wr_valid = 1; wr_data = 8'hA5; tick();
    wr_data = 8'h3C; tick();
    idle();
    chk(tx_full == 1, "R4", "tx_full single", tx_full, 1);
    chk(tx_out_data == 8'hA5, "R3", "held byte kept", tx_out_data, 8'hA5);
    rx_in_valid = 1; rx_in_data = 8'h11; tick();
    chk(rx_irq == 1, "R4", "rx_req level one", rx_irq, 1);
    rx_in_data = 8'h22; tick();
    idle();
    chk(rx_ovf == 1, "R6", "overflow set", rx_ovf, 1);
    rd_en = 1; tick();
    chk(rd_data == 8'h11, "R6", "first byte kept", rd_data, 8'h11);
    tick(); idle();
    chk(rd_data == 8'h11, "R5", "empty read holds", rd_data, 8'h11);
    status_rd = 1; tick(); idle();
    chk(rx_ovf == 0, "R7", "status read clears", rx_ovf, 0);

    // R11 enabling flushes (transmit still holds A5)
    fifo_en = 1; #1;
    chk(!wr_ready && !tx_out_valid, "R11", "flush cycle outputs", wr_ready, 0);
    tick();
    chk(tx_out_valid == 0, "R11", "tx flushed", tx_out_valid, 0);

    // R2 / R10 fill transmit queue
    tx_trig = 0; rx_trig = 4;
    for (int i = 0; i < 65; i++) begin
      wr_valid = 1; wr_data = 8'(i + 1); tick();
    end
    idle();
    chk(tx_full == 1, "R2", "tx full at 64", tx_full, 1);
    chk(tx_irq == 0, "R10", "zero level acts as one", tx_irq, 0);
    tx_trig = 100;
    for (int i = 0; i < 64; i++) begin
      tx_out_ready = 1; tick();
    end
    idle();
    chk(tx_irq == 1, "R10", "level above 64 saturates", tx_irq, 1);

    // R8 receive threshold
    for (int i = 0; i < 3; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(8'h40 + i); tick();
    end
    idle();
    chk(rx_irq == 0, "R8", "below level", rx_irq, 0);
    rx_in_valid = 1; rx_in_data = 8'h43; tick(); idle();
    chk(rx_irq == 1, "R8", "at level", rx_irq, 1);
    rd_en = 1; tick(); idle();
    chk(rx_irq == 0 && rd_data == 8'h40, "R8", "read drops below", rx_irq, 0);

    // R7 drop and status read in the same cycle
    for (int i = 0; i < 61; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(i); tick();
    end
    rx_in_data = 8'hEE; status_rd = 1; tick(); idle();
    chk(rx_ovf == 1, "R7", "set wins over clear", rx_ovf, 1);
    status_rd = 1; tick(); idle();
    chk(rx_ovf == 0, "R7", "later clear", rx_ovf, 0);

    // Randomised mix
    for (int c = 0; c < 4000; c++) begin
      wr_valid     = ($urandom % 2) == 0;
      wr_data      = 8'($urandom);
      tx_out_ready = ($urandom % 3) == 0;
      rx_in_valid  = ($urandom % 2) == 0;
      rx_in_data   = 8'($urandom);
      rd_en        = ($urandom % 3) == 0;
      status_rd    = ($urandom % 16) == 0;
      if ($urandom % 300 == 0) fifo_en = ~fifo_en;
      if ($urandom % 50 == 0) tx_trig = 7'($urandom % 80);
      if ($urandom % 50 == 0) rx_trig = 7'($urandom % 80);
      tick();
    end
    idle();
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule